// File: doc/BRIEF.md
# Firmware Flash Window Decoder with Write Guard

This block sits between a host memory-cycle port and a firmware flash port. For every valid host cycle it decides whether the address falls inside a flash window that software has opened, and whether the cycle may be passed on to the flash. Reads that hit an open window always pass. Writes pass only while software has switched write access on.

Software programs the block through a byte-wide register bus that has two registers. The window register opens a 64 KiB legacy window and four pairs of 1 MiB windows near the top of the 4 GiB space. The guard register holds a write-enable bit and a sticky lock bit. Once the lock bit is set, any register write that switches write access from off to on also raises a one-cycle system-management interrupt pulse. Interrupt-handler code can then check that the change was allowed.

Top module: `fwflash_guard`

## Requirements
- R1: After the synchronous active-low reset, both registers read 00h, every window is closed (cyc_hit=0, cyc_fwd=0) and smi_pulse is 0.
- R2: Bit 6 of the window register (offset D8h) opens the legacy window 000E_0000h to 000E_FFFFh.
- R3: Bit n (n = 0 to 3) of the window register opens two windows at once: FF(4+n)0_0000h to FF(4+n)F_FFFFh and FFn0_0000h to FFnF_FFFFh.
- R4: Bit 1 of the guard register (offset DCh) is the lock bit. Writing 1 sets it. Writing 0 leaves it unchanged, and only reset clears it.
- R5: While bit 0 of the guard register (the write-enable bit) is 0, a read cycle that hits gives cyc_fwd=1 and a write cycle that hits gives cyc_fwd=0.
- R6: While the write-enable bit is 1, both read and write cycles that hit give cyc_fwd=1.
- R7: A guard write that moves the write-enable bit from 0 to 1 while the lock bit is already 1 gives smi_pulse=1 for exactly the one cycle after that write's clock edge.
- R8: No pulse is produced when the lock bit was 0 before the write, including a single write that sets lock and enable together. No pulse is produced when the write-enable bit was already 1.
- R9: Window register bits 7, 5 and 4 and guard register bits 7:2 always read 0 and ignore writes. A read of any other offset returns 00h, and reg_rdata is 00h whenever reg_rd is 0.
- R10: A cycle outside every open window, or any cycle with cyc_valid=0, gives cyc_hit=0 and cyc_fwd=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low platform reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid in the same cycle as reg_rd |
| cyc_valid | input | 1 | A host memory cycle is present |
| cyc_write | input | 1 | 1 for a write cycle, 0 for a read cycle |
| cyc_addr | input | 32 | Host cycle byte address |
| cyc_hit | output | 1 | The cycle falls in an open window |
| cyc_fwd | output | 1 | The cycle is passed to the flash |
| smi_pulse | output | 1 | One-cycle system-management interrupt request |

## Verification
The assertions assume that the reset is held for at least one clock edge before any register or host activity is checked. They also assume that reg_wr and reg_rd are never high in the same cycle, and that reg_wr is not held high over consecutive enable-setting writes. The bench drives every input on the falling edge and pulses each strobe for exactly one cycle. Host cycles are presented only between register accesses, so a window or guard change is settled before any cycle is compared against it.

// File: rtl/fwflash_pkg.sv
package fwflash_pkg;
    parameter int ADDR_W   = 32;
    parameter int DATA_W   = 8;
    parameter int PAIRS    = 4;
    parameter logic [7:0] WIN_OFFS = 8'hD8;
    parameter logic [7:0] GRD_OFFS = 8'hDC;
    parameter int LEG_BIT  = 6;
    parameter logic [DATA_W-1:0] WIN_MASK = 8'h4F;
    parameter logic [DATA_W-1:0] GRD_MASK = 8'h03;

    typedef struct packed {
        logic [DATA_W-1:0] win;
        logic              wen;
        logic              lock;
        logic              smi;
    } regs_t;
endpackage

// File: rtl/fwflash_regs.sv
module fwflash_regs
    import fwflash_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] win_en,
    output logic              wen,
    output logic              smi
);
    regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.smi = 1'b0;
        if (reg_wr && reg_addr == WIN_OFFS) begin
            r_d.win = reg_wdata & WIN_MASK;
        end
        if (reg_wr && reg_addr == GRD_OFFS) begin
            // lock is sticky: set-only from software
            r_d.lock = r_q.lock | reg_wdata[1];
            r_d.wen  = reg_wdata[0];
            r_d.smi  = reg_wdata[0] & ~r_q.wen & r_q.lock;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            if (reg_addr == WIN_OFFS)      reg_rdata = r_q.win;
            else if (reg_addr == GRD_OFFS) reg_rdata = {6'b0, r_q.lock, r_q.wen} & GRD_MASK;
        end
    end

    assign win_en = r_q.win;
    assign wen    = r_q.wen;
    assign smi    = r_q.smi;

    p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.lock |=> r_q.lock);
    p_smi_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.smi) |-> ($past(r_q.lock) && !$past(r_q.wen) && r_q.wen));
    p_smi_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.smi |=> !r_q.smi);
    p_no_smi_unlocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.lock |=> !r_q.smi);
endmodule

// File: rtl/fwflash_decode.sv
module fwflash_decode
    import fwflash_pkg::*;
(
    input  logic              cyc_valid,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [DATA_W-1:0] win_en,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] MIB_SPAN = ADDR_W'(32'h000F_FFFF);
    localparam logic [ADDR_W-1:0] LEG_BASE = ADDR_W'(32'h000E_0000);
    localparam logic [ADDR_W-1:0] LEG_SPAN = ADDR_W'(32'h0000_FFFF);

    logic [PAIRS-1:0] pair_hit;

    for (genvar n = 0; n < PAIRS; n++) begin : g_pair
        localparam logic [ADDR_W-1:0] LO_BASE = ADDR_W'(32'hFF00_0000 + n * 32'h0010_0000);
        localparam logic [ADDR_W-1:0] HI_BASE = ADDR_W'(32'hFF00_0000 + (n + PAIRS) * 32'h0010_0000);
        logic in_lo, in_hi;
        assign in_lo = (cyc_addr >= LO_BASE) && (cyc_addr <= LO_BASE + MIB_SPAN);
        assign in_hi = (cyc_addr >= HI_BASE) && (cyc_addr <= HI_BASE + MIB_SPAN);
        assign pair_hit[n] = win_en[n] && (in_lo || in_hi);
    end

    logic leg_hit;
    assign leg_hit = win_en[LEG_BIT] && (cyc_addr >= LEG_BASE) && (cyc_addr <= LEG_BASE + LEG_SPAN);

    assign hit = cyc_valid && (leg_hit || (|pair_hit));
endmodule

// File: rtl/fwflash_gate.sv
module fwflash_gate (
    input  logic hit,
    input  logic cyc_write,
    input  logic wen,
    output logic fwd
);
    assign fwd = hit && (!cyc_write || wen);
endmodule

// File: rtl/fwflash_guard.sv
module fwflash_guard
    import fwflash_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cyc_valid,
    input  logic              cyc_write,
    input  logic [ADDR_W-1:0] cyc_addr,
    output logic              cyc_hit,
    output logic              cyc_fwd,
    output logic              smi_pulse
);
    logic [DATA_W-1:0] win_en;
    logic              wen;

    fwflash_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .win_en(win_en), .wen(wen), .smi(smi_pulse)
    );

    fwflash_decode u_dec (
        .cyc_valid(cyc_valid), .cyc_addr(cyc_addr), .win_en(win_en), .hit(cyc_hit)
    );

    fwflash_gate u_gate (
        .hit(cyc_hit), .cyc_write(cyc_write), .wen(wen), .fwd(cyc_fwd)
    );

    p_fwd_needs_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_fwd |-> cyc_hit);
    p_write_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_fwd && cyc_write) |-> wen);
    p_hit_in_space_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_hit |-> (cyc_addr[31:24] == 8'hFF || cyc_addr[31:16] == 16'h000E));
    p_reset_closed_r1: assert property (@(posedge clk)
        !rst_n |=> (!smi_pulse && !cyc_hit));
endmodule

// File: tb/fwflash_guard_test.sv
`timescale 1ns/1ps
module fwflash_guard_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
    logic cyc_valid = 1'b0, cyc_write = 1'b0;
    logic [31:0] cyc_addr = '0;
    logic cyc_hit, cyc_fwd, smi_pulse;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fwflash_guard uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cyc_valid(cyc_valid), .cyc_write(cyc_write), .cyc_addr(cyc_addr),
        .cyc_hit(cyc_hit), .cyc_fwd(cyc_fwd), .smi_pulse(smi_pulse)
    );

    // window register value, address, expected hit
    localparam int NV = 14;
    localparam logic [40:0] VEC [NV] = '{
        {8'h40, 32'h000E_0000, 1'b1},   // R2 low edge
        {8'h40, 32'h000E_FFFF, 1'b1},   // R2 high edge
        {8'h40, 32'h000F_0000, 1'b0},   // R10 just above
        {8'h40, 32'h000D_FFFF, 1'b0},   // R10 just below
        {8'h01, 32'hFF40_0000, 1'b1},   // R3 n=0 upper
        {8'h01, 32'hFF0F_FFFF, 1'b1},   // R3 n=0 lower
        {8'h01, 32'hFF10_0000, 1'b0},   // R10 n=1 closed
        {8'h02, 32'hFF5F_FFFF, 1'b1},   // R3 n=1 upper
        {8'h02, 32'hFF10_0000, 1'b1},   // R3 n=1 lower
        {8'h04, 32'hFF60_1234, 1'b1},   // R3 n=2
        {8'h08, 32'hFF3A_BCDE, 1'b1},   // R3 n=3 lower
        {8'h08, 32'hFF80_0000, 1'b0},   // R10 above pairs
        {8'h0F, 32'hFE7F_FFFF, 1'b0},   // R10 below FF space
        {8'h4F, 32'h000E_8000, 1'b1}    // R2 with all open
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic host(input logic [31:0] a, input logic wr);
        @(negedge clk);
        cyc_valid = 1'b1; cyc_addr = a; cyc_write = wr;
        #1;
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        reg_read(8'hD8, rd); check("R1 win", rd, 8'h00);
        reg_read(8'hDC, rd); check("R1 guard", rd, 8'h00);
        host(32'hFF40_0000, 1'b0);
        check("R1 hit", cyc_hit, 0); check("R1 smi", smi_pulse, 0);
        cyc_valid = 1'b0;

        // table walk: R2 R3 R10
        for (int i = 0; i < NV; i++) begin
            reg_write(8'hD8, VEC[i][40:33]);
            host(VEC[i][32:1], 1'b0);
            check($sformatf("R2/R3/R10 vec%0d hit", i), cyc_hit, VEC[i][0]);
            check($sformatf("R5 vec%0d read fwd", i), cyc_fwd, VEC[i][0]);
            cyc_valid = 1'b0;
        end

        // R10 invalid cycle
        reg_write(8'hD8, 8'h4F);
        host(32'hFF40_0000, 1'b0); cyc_valid = 1'b0; #1;
        check("R10 valid low", cyc_hit, 0);

        // R9 reserved bits and unknown offsets
        reg_write(8'hD8, 8'hFF);
        reg_read(8'hD8, rd); check("R9 win mask", rd, 8'h4F);
        reg_read(8'h10, rd); check("R9 other offs", rd, 8'h00);
        @(negedge clk); #1; check("R9 rd idle", reg_rdata, 8'h00);

        // R5 write blocked while enable off
        host(32'hFF20_0000, 1'b1);
        check("R5 write hit", cyc_hit, 1); check("R5 write blocked", cyc_fwd, 0);
        cyc_valid = 1'b0;

        // R8 set enable without lock: no pulse
        reg_write(8'hDC, 8'h01);
        check("R8 unlocked smi", smi_pulse, 0);
        host(32'hFF20_0000, 1'b1);
        check("R6 write fwd", cyc_fwd, 1);
        host(32'hFF20_0000, 1'b0);
        check("R6 read fwd", cyc_fwd, 1);
        cyc_valid = 1'b0;
        // R8 lock and enable in one write, enable already 1 -> no pulse
        reg_write(8'hDC, 8'hFF);
        check("R8 already on", smi_pulse, 0);
        reg_read(8'hDC, rd); check("R9 guard mask", rd, 8'h03);

        // R4 lock sticky
        reg_write(8'hDC, 8'h00);
        reg_read(8'hDC, rd); check("R4 lock kept", rd, 8'h02);

        // R7 enable 0->1 under lock
        reg_write(8'hDC, 8'h01);
        check("R7 pulse", smi_pulse, 1);
        @(negedge clk); #1; check("R7 one cycle", smi_pulse, 0);
        reg_write(8'hDC, 8'h01);
        check("R8 repeat no pulse", smi_pulse, 0);

        // R8 fresh reset, lock+enable together
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        reg_read(8'hDC, rd); check("R4 reset clears lock", rd, 8'h00);
        reg_write(8'hDC, 8'h03);
        check("R8 joint set", smi_pulse, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule